// File: doc/BRIEF.md
# Most-Significant-Bit Address Remapper

This block turns 32-bit logical addresses into physical addresses without any page table. Each access path has a mapping made of two things: a process identifier and a log2 region size. The low `size` bits of an address are the offset inside the task's region and pass through unchanged. Every bit at or above `size` is overwritten with the process identifier, truncated to fit the field that remains. The result is a set of power-of-two regions of at least 256 bytes, one per identifier.

An address whose upper field (bits `size` and above) is all zeros or all ones belongs to a shared region. It leaves the block unchanged and is marked as shared. Instruction fetches and operand accesses each have their own mapping and their own translation path. A configuration port writes one mapping at a time, and it accepts a write only while the supervisor input is high.

Each path computes its translation combinationally from the request address and registers the result, so the result appears exactly one cycle after the request. A bound flag is raised when a remapped access uses a process identifier too wide for the field it has to fill, because the identifier loses bits when it is truncated.

Top module: `msb_remap_top`

## Requirements
- R1: While reset is held, and after it, every output valid is low and every physical address and flag is zero. Both mappings reset to size 31 and identifier 0, so every address then passes through unchanged with the shared flag set.
- R2: A translated physical address keeps the logical address bits below the path's size value unchanged, and bits 7:0 are always kept.
- R3: If the upper field of the logical address is neither all zeros nor all ones, physical bits 31 down to `size` carry identifier bits `31-size` down to 0, and shared is 0.
- R4: If the upper field is all zeros or all ones, the physical address equals the logical address, shared is 1 and bound is 0.
- R5: Bound is 1 only for a remapped access whose identifier has a set bit at position `32-size` or above. Shared and bound are never 1 together.
- R6: A size value below 8 that is written through the configuration port is stored as 8. The valid range is 8 to 31.
- R7: `cfg_sel` = 0 writes the fetch mapping and `cfg_sel` = 1 writes the operand mapping. A write to one mapping leaves the other mapping's translations unchanged.
- R8: A write with `sup_en` low changes no mapping.
- R9: A mapping write takes effect for requests from the next cycle on. A request in the same cycle as the write still uses the old mapping.
- R10: A request's results appear exactly one cycle later with valid high. In a cycle after no request, valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sup_en | input | 1 | Supervisor mode; enables configuration writes |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | Mapping select: 0 fetch, 1 operand |
| cfg_pid | input | 24 | Process identifier to store |
| cfg_size | input | 5 | Log2 region size to store (clamped to 8..31) |
| if_req | input | 1 | Fetch translation request |
| if_addr | input | 32 | Fetch logical address |
| if_paddr | output | 32 | Fetch physical address |
| if_shared | output | 1 | Fetch access hit a shared region |
| if_bound | output | 1 | Fetch identifier too wide for its field |
| if_valid | output | 1 | Fetch result valid |
| op_req | input | 1 | Operand translation request |
| op_addr | input | 32 | Operand logical address |
| op_paddr | output | 32 | Operand physical address |
| op_shared | output | 1 | Operand access hit a shared region |
| op_bound | output | 1 | Operand identifier too wide for its field |
| op_valid | output | 1 | Operand result valid |

## Verification
The assertions check, on every cycle, the properties that do not depend on the mapping's value. The stored size never leaves 8..31. A mapping moves only under a supervisor write that selects it. The low byte always passes through. A shared result equals the address of the request one cycle earlier. Shared and bound never coincide, and valid follows the request by one cycle. Only the bench scenarios show the exact remapped values for particular identifier and size pairs, that a small size is clamped, and that the two mappings stay independent. They also show the boundary between a write and the first request that sees it.

// File: rtl/msb_remap_pkg.sv
// Package: shared constants and types for the MSB address remapper.
// Assumes a byte-addressed logical space of ADDR_W bits and a minimum region of 2**MIN_LOG bytes.
package msb_remap_pkg;
    localparam int ADDR_W  = 32;
    localparam int MIN_LOG = 8;
    localparam int SIZE_W  = $clog2(ADDR_W);
    localparam int PID_W   = ADDR_W - MIN_LOG;
    localparam int N_PATH  = 2;

    // Access path index; the value is also the cfg_sel encoding.
    typedef enum logic {
        PATH_FETCH = 1'b0,
        PATH_OPND  = 1'b1
    } path_e;
endpackage

// File: rtl/msb_remap_cfg.sv
// Module: mapping register bank, one identifier/size pair per access path.
// Assumes writes arrive only through the supervisor-gated port; a size below
// MIN_LOG is clamped on the way in. Reset gives an identity mapping (size AW-1).
module msb_remap_cfg #(
    parameter int AW    = msb_remap_pkg::ADDR_W,
    parameter int MINL  = msb_remap_pkg::MIN_LOG,
    parameter int NP    = msb_remap_pkg::N_PATH,
    localparam int SZW  = $clog2(AW),
    localparam int PIDW = AW - MINL,
    localparam int SELW = (NP > 1) ? $clog2(NP) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sup,
    input  logic                 we,
    input  logic [SELW-1:0]      sel,
    input  logic [PIDW-1:0]      pid_in,
    input  logic [SZW-1:0]       size_in,
    output logic [NP-1:0][PIDW-1:0] pid_q,
    output logic [NP-1:0][SZW-1:0]  size_q
);
    logic [SZW-1:0] size_clamped;
    logic           wr_ok;

    // Clamp the requested size to the legal range.
    always_comb begin
        size_clamped = (size_in < SZW'(MINL)) ? SZW'(MINL) : size_in;
        wr_ok        = sup && we;
    end

    for (genvar g = 0; g < NP; g++) begin : g_slot
        logic hit;
        assign hit = wr_ok && (sel == SELW'(g));

        // Hold one path's mapping; load it on a gated, selected write.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                pid_q[g]  <= '0;
                size_q[g] <= SZW'(AW - 1);
            end else if (hit) begin
                pid_q[g]  <= pid_in;
                size_q[g] <= size_clamped;
            end
        end

        // Stored size always stays in the legal window.
        assert_size_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (size_q[g] >= SZW'(MINL)) && (size_q[g] <= SZW'(AW - 1)));

        // Mapping only moves on a supervisor write that selects this slot.
        assert_write_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
            !(sup && we && (sel == SELW'(g))) |=> ($stable(pid_q[g]) && $stable(size_q[g])));
    end
endmodule

// File: rtl/msb_remap_xlate.sv
// Module: one translation path. Combinational remap of the logical address
// followed by a single output register stage.
// Assumes size is within MINL..AW-1 (guaranteed by the register bank).
module msb_remap_xlate #(
    parameter int AW    = msb_remap_pkg::ADDR_W,
    parameter int MINL  = msb_remap_pkg::MIN_LOG,
    localparam int SZW  = $clog2(AW),
    localparam int PIDW = AW - MINL
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PIDW-1:0] pid,
    input  logic [SZW-1:0]  size,
    input  logic            req,
    input  logic [AW-1:0]   addr,
    output logic [AW-1:0]   paddr,
    output logic            shared,
    output logic            bound,
    output logic            valid
);
    logic [AW-1:0]  keep_m;
    logic [AW-1:0]  pid_ext;
    logic [AW-1:0]  pid_sh;
    logic [SZW:0]   rep_w;
    logic           up_zero;
    logic           up_ones;
    logic           esc;
    logic           pid_wide;
    logic [AW-1:0]  paddr_d;

    // Build the pass-through mask and classify the upper field.
    always_comb begin
        keep_m   = ~({AW{1'b1}} << size);
        up_zero  = (addr & ~keep_m) == '0;
        up_ones  = (addr | keep_m) == {AW{1'b1}};
        esc      = up_zero || up_ones;
        pid_ext  = AW'(pid);
        pid_sh   = pid_ext << size;
        rep_w    = (SZW + 1)'(AW) - {1'b0, size};
        pid_wide = (pid_ext >> rep_w) != '0;
        paddr_d  = esc ? addr : (pid_sh | (addr & keep_m));
    end

    // Register the translation for one cycle of latency.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            paddr  <= '0;
            shared <= 1'b0;
            bound  <= 1'b0;
            valid  <= 1'b0;
        end else begin
            valid <= req;
            if (req) begin
                paddr  <= paddr_d;
                shared <= esc;
                bound  <= !esc && pid_wide;
            end
        end
    end

    assert_low_byte_R2: assert property (@(posedge clk) disable iff (!rst_n)
        req |=> (paddr[MINL-1:0] == $past(addr[MINL-1:0])));

    assert_shared_identity_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (req && (($past(1'b1)) == 1'b1)) |=> (!shared || (paddr == $past(addr))));

    assert_flag_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> !(shared && bound));

    assert_valid_follow_R10: assert property (@(posedge clk) disable iff (!rst_n)
        req |=> valid);

    assert_valid_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !req |=> !valid);
endmodule

// File: rtl/msb_remap_top.sv
// Module: MSB address remapper top. One supervisor-gated configuration port
// and two translation paths (fetch, operand), each with its own mapping.
// Assumes synchronous active-low reset and a single clock domain.
module msb_remap_top #(
    parameter int AW    = msb_remap_pkg::ADDR_W,
    parameter int MINL  = msb_remap_pkg::MIN_LOG,
    localparam int SZW  = $clog2(AW),
    localparam int PIDW = AW - MINL,
    localparam int NP   = msb_remap_pkg::N_PATH
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sup_en,
    input  logic            cfg_we,
    input  logic            cfg_sel,
    input  logic [PIDW-1:0] cfg_pid,
    input  logic [SZW-1:0]  cfg_size,
    input  logic            if_req,
    input  logic [AW-1:0]   if_addr,
    output logic [AW-1:0]   if_paddr,
    output logic            if_shared,
    output logic            if_bound,
    output logic            if_valid,
    input  logic            op_req,
    input  logic [AW-1:0]   op_addr,
    output logic [AW-1:0]   op_paddr,
    output logic            op_shared,
    output logic            op_bound,
    output logic            op_valid
);
    import msb_remap_pkg::*;

    logic [NP-1:0][PIDW-1:0] pid_q;
    logic [NP-1:0][SZW-1:0]  size_q;
    logic [NP-1:0]           req_v;
    logic [NP-1:0][AW-1:0]   addr_v;
    logic [NP-1:0][AW-1:0]   paddr_v;
    logic [NP-1:0]           shared_v;
    logic [NP-1:0]           bound_v;
    logic [NP-1:0]           valid_v;

    msb_remap_cfg #(.AW(AW), .MINL(MINL), .NP(NP)) cfg_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .sup     (sup_en),
        .we      (cfg_we),
        .sel     (cfg_sel),
        .pid_in  (cfg_pid),
        .size_in (cfg_size),
        .pid_q   (pid_q),
        .size_q  (size_q)
    );

    // Gather the per-path request ports into indexed vectors.
    always_comb begin
        req_v[PATH_FETCH]  = if_req;
        addr_v[PATH_FETCH] = if_addr;
        req_v[PATH_OPND]   = op_req;
        addr_v[PATH_OPND]  = op_addr;
    end

    for (genvar p = 0; p < NP; p++) begin : g_path
        msb_remap_xlate #(.AW(AW), .MINL(MINL)) xl_i (
            .clk    (clk),
            .rst_n  (rst_n),
            .pid    (pid_q[p]),
            .size   (size_q[p]),
            .req    (req_v[p]),
            .addr   (addr_v[p]),
            .paddr  (paddr_v[p]),
            .shared (shared_v[p]),
            .bound  (bound_v[p]),
            .valid  (valid_v[p])
        );
    end

    // Spread the per-path results back onto the named ports.
    always_comb begin
        if_paddr  = paddr_v[PATH_FETCH];
        if_shared = shared_v[PATH_FETCH];
        if_bound  = bound_v[PATH_FETCH];
        if_valid  = valid_v[PATH_FETCH];
        op_paddr  = paddr_v[PATH_OPND];
        op_shared = shared_v[PATH_OPND];
        op_bound  = bound_v[PATH_OPND];
        op_valid  = valid_v[PATH_OPND];
    end
endmodule

// File: tb/msb_remap_top_tb.sv
// Bench: vector table walked on the operand path, then directed reset,
// separation, gating, write-timing and latency tests.
module msb_remap_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sup_en = 1'b0, cfg_we = 1'b0, cfg_sel = 1'b0;
    logic [23:0] cfg_pid = '0;
    logic [4:0]  cfg_size = '0;
    logic        if_req = 1'b0, op_req = 1'b0;
    logic [31:0] if_addr = '0, op_addr = '0;
    logic [31:0] if_paddr, op_paddr;
    logic        if_shared, if_bound, if_valid, op_shared, op_bound, op_valid;

    int n_chk = 0;
    int n_err = 0;

    always #5 clk = ~clk;

    msb_remap_top dut_i (.*);

    localparam int NV = 9;
    localparam logic [23:0] V_PID  [NV] = '{24'h5, 24'h5, 24'h5, 24'hABC, 24'h123, 24'h1FF, 24'h77, 24'h3, 24'h2};
    localparam logic [4:0]  V_SZ   [NV] = '{5'd16, 5'd16, 5'd16, 5'd12, 5'd8, 5'd24, 5'd4, 5'd31, 5'd30};
    localparam logic [31:0] V_ADDR [NV] = '{32'h0003_1234, 32'h0000_ABCD, 32'hFFFF_0010, 32'h1234_5678,
                                           32'h8000_00FF, 32'h0100_0042, 32'h0000_1234, 32'h8000_0000, 32'h4000_0001};
    localparam logic [31:0] V_EXP  [NV] = '{32'h0005_1234, 32'h0000_ABCD, 32'hFFFF_0010, 32'h00AB_C678,
                                           32'h0001_23FF, 32'hFF00_0042, 32'h0000_7734, 32'h8000_0000, 32'h8000_0001};
    localparam logic        V_SH   [NV] = '{1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0};
    localparam logic        V_BD   [NV] = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0};

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic cfg_write(input logic sup, input logic sel, input logic [23:0] pid, input logic [4:0] sz);
        @(negedge clk);
        sup_en = sup; cfg_we = 1'b1; cfg_sel = sel; cfg_pid = pid; cfg_size = sz;
        @(negedge clk);
        cfg_we = 1'b0; sup_en = 1'b0;
    endtask

    // Issue one request on a path at a negedge; results are read at the next negedge.
    task automatic issue(input logic sel, input logic [31:0] a);
        if (sel) begin op_req = 1'b1; op_addr = a; end
        else     begin if_req = 1'b1; if_addr = a; end
        @(negedge clk);
        op_req = 1'b0; if_req = 1'b0;
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
        $finish;
    end

    initial begin : main
        // R1: outputs while reset is held
        if_req = 1'b1; op_req = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 valid in reset", {30'b0, if_valid, op_valid}, 32'h0);
        chk("R1 paddr in reset", op_paddr | if_paddr, 32'h0);
        chk("R1 flags in reset", {28'b0, if_shared, if_bound, op_shared, op_bound}, 32'h0);
        if_req = 1'b0; op_req = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 valid after reset", {30'b0, if_valid, op_valid}, 32'h0);
        // R1: identity mapping after reset
        issue(1'b0, 32'h1234_5678);
        chk("R1 identity paddr", if_paddr, 32'h1234_5678);
        chk("R1 identity shared", {31'b0, if_shared}, 32'h1);

        // Vector table on operand path: R2 R3 R4 R5 R6
        for (int i = 0; i < NV; i++) begin
            cfg_write(1'b1, 1'b1, V_PID[i], V_SZ[i]);
            issue(1'b1, V_ADDR[i]);
            chk("R3/R2/R6 paddr", op_paddr, V_EXP[i]);
            chk("R4 shared", {31'b0, op_shared}, {31'b0, V_SH[i]});
            chk("R5 bound", {31'b0, op_bound}, {31'b0, V_BD[i]});
            chk("R10 valid", {31'b0, op_valid}, 32'h1);
        end

        // R7: separate mappings
        cfg_write(1'b1, 1'b0, 24'h9, 5'd16);
        issue(1'b0, 32'h0007_0001);
        chk("R7 fetch mapping", if_paddr, 32'h0009_0001);
        cfg_write(1'b1, 1'b1, 24'h4, 5'd16);
        issue(1'b1, 32'h0007_0001);
        chk("R7 operand mapping", op_paddr, 32'h0004_0001);
        issue(1'b0, 32'h0007_0001);
        chk("R7 fetch unchanged", if_paddr, 32'h0009_0001);

        // R8: write without supervisor ignored
        cfg_write(1'b0, 1'b1, 24'hEE, 5'd12);
        issue(1'b1, 32'h0007_0001);
        chk("R8 gated write", op_paddr, 32'h0004_0001);

        // R9: same-cycle write uses old mapping, next cycle uses new
        @(negedge clk);
        sup_en = 1'b1; cfg_we = 1'b1; cfg_sel = 1'b1; cfg_pid = 24'h6; cfg_size = 5'd16;
        op_req = 1'b1; op_addr = 32'h0007_0001;
        @(negedge clk);
        cfg_we = 1'b0; sup_en = 1'b0;
        chk("R9 old mapping", op_paddr, 32'h0004_0001);
        @(negedge clk);
        op_req = 1'b0;
        chk("R9 new mapping", op_paddr, 32'h0006_0001);

        // R10: no request means valid low next cycle
        @(negedge clk);
        chk("R10 idle valid", {31'b0, op_valid}, 32'h0);
        chk("R10 idle fetch valid", {31'b0, if_valid}, 32'h0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
        $finish;
    end
endmodule